// File: doc/BRIEF.md
# Level-Parallel Max-Heap Builder

This block holds a complete binary tree of `NODES = 2^LEVELS - 1` unsigned values in registers and rearranges them into max-heap order in place. Node `i` has its children at `2i+1` and `2i+2`. Every node that has children owns a small compare-and-swap unit. The unit looks at its own value and both child values. If the larger child is bigger than the node, the two values trade places.

Values go in through an indexed write port. A single-cycle `start` launches the run. A scheduler then enables one tree level per cycle, deepest parent level first and the root last. That makes one pass. It repeats the pass `LEVELS` times, so a run lasts `LEVELS*(LEVELS-1)` cycles, which grows with the square of the tree depth. All nodes on the enabled level act together. Two neighbouring levels are never enabled in the same cycle, so no register has two writers. When the run ends, `done` rises, and the result can be read back through a combinational read port.

The scheduler has three states:
- `SCH_IDLE`: accepts writes. `start` moves it to `SCH_SWEEP`.
- `SCH_SWEEP`: steps down through the levels and counts passes. After the root step of the last pass it moves to `SCH_DONE`.
- `SCH_DONE`: keeps `done` high. `start` moves it back to `SCH_SWEEP`. An accepted write moves it to `SCH_IDLE`.

Top module: `heap_build_top`

## Requirements
- R1: After reset every node holds 0, and `busy` and `done` are both low.
- R2: While not busy, a write with `wr_en` high and `wr_idx < NODES` stores `wr_data` at that node. A write with `wr_idx >= NODES` is dropped. `rd_data` shows node `rd_idx` combinationally, or 0 when `rd_idx >= NODES`.
- R3: A `start` pulse sampled while idle or done raises `busy` from the next cycle. `busy` then stays high for exactly `LEVELS*(LEVELS-1)` cycles (12 for the default of 4 levels). `done` rises in the cycle after the last busy cycle.
- R4: When `done` is high, every node with children holds a value greater than or equal to each of its children.
- R5: The values present after the run are the same multiset as the values loaded before it.
- R6: When a node's larger child exceeds the node, the node swaps with that child. If both children are equal, the left child (`2i+1`) is used.
- R7: Writes presented while `busy` is high change no node.
- R8: `done` stays high until the next accepted `start` or accepted write. A `start` pulse during a run is ignored and does not lengthen it.
- R9: The final arrangement equals `LEVELS` passes. Each pass processes tree levels `LEVELS-2` down to 0, one level per cycle, and applies the R6 rule at every node of the active level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one node |
| wr_idx | input | IDXW | Node index for writes |
| wr_data | input | WIDTH | Value to store |
| start | input | 1 | Launches a heapify run |
| rd_idx | input | IDXW | Node index for reads |
| rd_data | output | WIDTH | Value held at `rd_idx` |
| busy | output | 1 | High while the run is sweeping levels |
| done | output | 1 | High after a run completes |

## Verification
The tree is loaded with several kinds of data:
- Wide-range random values, which exercise multi-level sinking.
- Values drawn from only four codes, which create many equal children and so test the left-child tie rule.
- Ascending data, which is the worst case and moves small values down the full depth.
- Descending data, which is already a heap and must come through untouched.

Each result is compared node-for-node with a model of the pass schedule. This separates a wrong pass count or level order from a merely valid heap. Directed cases isolate the swap choice, writes and a stray `start` arriving mid-run, and the persistence of `done`.

// File: rtl/heap_build_pkg.sv
package heap_build_pkg;
    typedef enum logic [1:0] {
        SCH_IDLE  = 2'd0,
        SCH_SWEEP = 2'd1,
        SCH_DONE  = 2'd2
    } sched_state_e;
endpackage

// File: rtl/heap_node_cas.sv
module heap_node_cas #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] self_val,
    input  logic [WIDTH-1:0] left_val,
    input  logic [WIDTH-1:0] right_val,
    output logic             take_left,
    output logic             take_right
);
    logic left_wins;

    always_comb begin
        left_wins  = (left_val >= right_val);
        take_left  = left_wins && (left_val > self_val);
        take_right = !left_wins && (right_val > self_val);
    end
endmodule

// File: rtl/heap_level_sched.sv
module heap_level_sched
    import heap_build_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int LVW    = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           wr_take,
    output logic           busy,
    output logic           done,
    output logic           step_en,
    output logic [LVW-1:0] act_lvl
);
    localparam int PW        = $clog2(LEVELS + 1);
    localparam int TOP_LVL   = LEVELS - 2;
    localparam int LAST_PASS = LEVELS - 1;
    localparam int RUN_LEN   = LEVELS * (LEVELS - 1);
    localparam int CW        = $clog2(RUN_LEN + 1) + 1;

    sched_state_e   state_q, state_d;
    logic [LVW-1:0] lvl_q, lvl_d;
    logic [PW-1:0]  pass_q, pass_d;

    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        pass_d  = pass_q;
        unique case (state_q)
            SCH_IDLE: begin
                if (start) begin
                    state_d = SCH_SWEEP;
                    lvl_d   = LVW'(TOP_LVL);
                    pass_d  = '0;
                end
            end
            SCH_SWEEP: begin
                if (lvl_q == '0) begin
                    if (pass_q == PW'(LAST_PASS)) begin
                        state_d = SCH_DONE;
                    end else begin
                        pass_d = pass_q + 1'b1;
                        lvl_d  = LVW'(TOP_LVL);
                    end
                end else begin
                    lvl_d = lvl_q - 1'b1;
                end
            end
            SCH_DONE: begin
                if (start) begin
                    state_d = SCH_SWEEP;
                    lvl_d   = LVW'(TOP_LVL);
                    pass_d  = '0;
                end else if (wr_take) begin
                    state_d = SCH_IDLE;
                end
            end
            default: state_d = SCH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCH_IDLE;
            lvl_q   <= '0;
            pass_q  <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
            pass_q  <= pass_d;
        end
    end

    always_comb begin
        busy    = (state_q == SCH_SWEEP);
        done    = (state_q == SCH_DONE);
        step_en = (state_q == SCH_SWEEP);
        act_lvl = lvl_q;
    end

    // checker counter: cycles spent sweeping in the current run
    logic [CW-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (state_q != SCH_SWEEP && state_d == SCH_SWEEP) begin
            run_cnt <= '0;
        end else if (state_q == SCH_SWEEP) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    a_r3_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (run_cnt == CW'(RUN_LEN)));

    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start && !wr_take) |=> done);

    a_r8_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && lvl_q != '0) |=> busy);

    a_r9_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lvl_q <= LVW'(TOP_LVL)));
endmodule

// File: rtl/heap_build_top.sv
module heap_build_top
    import heap_build_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int WIDTH  = 8,
    parameter int IDXW   = $clog2((1 << LEVELS) - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             start,
    input  logic [IDXW-1:0]  rd_idx,
    output logic [WIDTH-1:0] rd_data,
    output logic             busy,
    output logic             done
);
    localparam int NODES   = (1 << LEVELS) - 1;
    localparam int PARENTS = (1 << (LEVELS - 1)) - 1;
    localparam int LVW     = (LEVELS > 2) ? $clog2(LEVELS) : 1;
    localparam int SUMW    = WIDTH + IDXW + 1;

    logic [WIDTH-1:0] vals_q [NODES];
    logic [WIDTH-1:0] vals_d [NODES];
    logic             sw_l   [PARENTS];
    logic             sw_r   [PARENTS];
    logic             step_en;
    logic [LVW-1:0]   act_lvl;
    logic             wr_take;

    assign wr_take = wr_en && !busy && (int'(wr_idx) < NODES);

    heap_level_sched #(.LEVELS(LEVELS), .LVW(LVW)) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .wr_take (wr_take),
        .busy    (busy),
        .done    (done),
        .step_en (step_en),
        .act_lvl (act_lvl)
    );

    for (genvar p = 0; p < PARENTS; p++) begin : g_cas
        heap_node_cas #(.WIDTH(WIDTH)) u_cas (
            .self_val   (vals_q[p]),
            .left_val   (vals_q[2*p+1]),
            .right_val  (vals_q[2*p+2]),
            .take_left  (sw_l[p]),
            .take_right (sw_r[p])
        );
    end

    always_comb begin
        for (int i = 0; i < NODES; i++) vals_d[i] = vals_q[i];
        if (step_en) begin
            for (int p = 0; p < PARENTS; p++) begin
                if (((p + 1) >> act_lvl) == 1) begin
                    if (sw_l[p]) begin
                        vals_d[p]     = vals_q[2*p+1];
                        vals_d[2*p+1] = vals_q[p];
                    end else if (sw_r[p]) begin
                        vals_d[p]     = vals_q[2*p+2];
                        vals_d[2*p+2] = vals_q[p];
                    end
                end
            end
        end else if (wr_take) begin
            vals_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NODES; i++) vals_q[i] <= '0;
        end else begin
            for (int i = 0; i < NODES; i++) vals_q[i] <= vals_d[i];
        end
    end

    assign rd_data = (int'(rd_idx) < NODES) ? vals_q[rd_idx] : '0;

    // checker signals
    logic            heap_ok;
    logic [SUMW-1:0] val_sum;
    always_comb begin
        heap_ok = 1'b1;
        val_sum = '0;
        for (int i = 0; i < NODES; i++) val_sum = val_sum + SUMW'(vals_q[i]);
        for (int p = 0; p < PARENTS; p++) begin
            if (vals_q[p] < vals_q[2*p+1] || vals_q[p] < vals_q[2*p+2]) heap_ok = 1'b0;
        end
    end

    a_r4_heap_order: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> heap_ok);

    // R5 and R7: swaps keep the total, and busy writes cannot alter it
    a_r5_sum_kept: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (val_sum == $past(val_sum)));

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && int'(wr_idx) < NODES) |=> (vals_q[$past(wr_idx)] == $past(wr_data)));

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy && !done));
endmodule

// File: tb/tb_heap_build_top.sv
module tb_heap_build_top;
    localparam int CLK_PERIOD = 10;
    localparam int LV   = 4;
    localparam int WD   = 8;
    localparam int NN   = (1 << LV) - 1;
    localparam int NP   = (1 << (LV - 1)) - 1;
    localparam int IW   = $clog2(NN);
    localparam int RUNC = LV * (LV - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [WD-1:0] wr_data = '0;
    logic          start = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic [WD-1:0] rd_data;
    logic          busy;
    logic          done;

    int checks = 0;
    int errors = 0;

    logic [WD-1:0] loaded [NN];
    logic [WD-1:0] model  [NN];
    logic [WD-1:0] got    [NN];

    heap_build_top #(.LEVELS(LV), .WIDTH(WD)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .start(start), .rd_idx(rd_idx),
        .rd_data(rd_data), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_all();
        for (int i = 0; i < NN; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_idx = IW'(i); wr_data = loaded[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_all();
        for (int i = 0; i < NN; i++) begin
            rd_idx = IW'(i);
            #1;
            got[i] = rd_data;
        end
    endtask

    // schedule model: LV passes, levels LV-2 down to 0, larger child, tie left
    task automatic model_run();
        for (int i = 0; i < NN; i++) model[i] = loaded[i];
        for (int p = 0; p < LV; p++) begin
            for (int lv = LV - 2; lv >= 0; lv--) begin
                for (int n = (1 << lv) - 1; n <= (1 << (lv + 1)) - 2; n++) begin
                    logic [WD-1:0] tmp;
                    int c;
                    c = (model[2*n+1] >= model[2*n+2]) ? 2*n+1 : 2*n+2;
                    if (model[c] > model[n]) begin
                        tmp = model[n]; model[n] = model[c]; model[c] = tmp;
                    end
                end
            end
        end
    endtask

    task automatic run_heap(input bit inj_start, input bit inj_write, output int cyc);
        int k;
        cyc = 0; k = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && k < 1000) begin
            if (busy) cyc++;
            start   = inj_start && (k == 3);
            wr_en   = inj_write && (k == 5);
            wr_idx  = IW'(3);
            wr_data = 8'd200;
            k++;
            @(negedge clk);
        end
        start = 1'b0; wr_en = 1'b0;
    endtask

    function automatic int heap_violations();
        int v = 0;
        for (int p = 0; p < NP; p++)
            if (got[p] < got[2*p+1] || got[p] < got[2*p+2]) v++;
        return v;
    endfunction

    function automatic int multiset_diff();
        int cnt_a [256];
        int d = 0;
        for (int v = 0; v < 256; v++) cnt_a[v] = 0;
        for (int i = 0; i < NN; i++) cnt_a[loaded[i]]++;
        for (int i = 0; i < NN; i++) cnt_a[got[i]]--;
        for (int v = 0; v < 256; v++) if (cnt_a[v] != 0) d++;
        return d;
    endfunction

    function automatic int model_mismatch();
        int m = 0;
        for (int i = 0; i < NN; i++) if (got[i] != model[i]) m++;
        return m;
    endfunction

    task automatic full_trial(input string tag);
        int cyc;
        load_all();
        model_run();
        run_heap(1'b0, 1'b0, cyc);
        check("R3 run length", cyc, RUNC);
        check("R3 done raised", int'(done), 1);
        read_all();
        check("R4 heap order violations", heap_violations(), 0);
        check("R5 multiset differences", multiset_diff(), 0);
        check("R9 node mismatches vs pass model", model_mismatch(), 0);
        if (model_mismatch() != 0) $display("  trial %s", tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R3 watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        read_all();
        begin
            int nz = 0;
            for (int i = 0; i < NN; i++) if (got[i] != 0) nz++;
            check("R1 nonzero nodes", nz, 0);
        end

        // R2 write and read back, out-of-range index
        @(negedge clk); wr_en = 1'b1; wr_idx = IW'(7); wr_data = 8'd77;
        @(negedge clk); wr_en = 1'b1; wr_idx = IW'(15); wr_data = 8'd99;
        @(negedge clk); wr_en = 1'b0;
        rd_idx = IW'(7); #1;
        check("R2 readback node 7", int'(rd_data), 77);
        rd_idx = IW'(15); #1;
        check("R2 out-of-range read", int'(rd_data), 0);
        read_all();
        begin
            int s = 0;
            for (int i = 0; i < NN; i++) s += int'(got[i]);
            check("R2 out-of-range write dropped (sum)", s, 77);
        end

        // R6 larger child chosen
        for (int i = 0; i < NN; i++) loaded[i] = 8'd0;
        loaded[0] = 8'd1; loaded[1] = 8'd3; loaded[2] = 8'd7;
        load_all();
        run_heap(1'b0, 1'b0, cyc);
        read_all();
        check("R6 root takes larger child", int'(got[0]), 7);
        check("R6 right child gets old root", int'(got[2]), 1);
        check("R6 left child untouched", int'(got[1]), 3);

        // R6 tie goes left
        for (int i = 0; i < NN; i++) loaded[i] = 8'd0;
        loaded[0] = 8'd1; loaded[1] = 8'd5; loaded[2] = 8'd5;
        load_all();
        run_heap(1'b0, 1'b0, cyc);
        read_all();
        check("R6 tie: left child gets old root", int'(got[1]), 1);
        check("R6 tie: right child keeps value", int'(got[2]), 5);

        // R7 write during busy ignored
        for (int i = 0; i < NN; i++) loaded[i] = 8'd9;
        load_all();
        run_heap(1'b0, 1'b1, cyc);
        rd_idx = IW'(3); #1;
        check("R7 busy write dropped", int'(rd_data), 9);

        // R8 stray start during run ignored, done persists, write clears it
        for (int i = 0; i < NN; i++) loaded[i] = 8'(i * 13);
        load_all();
        model_run();
        run_heap(1'b1, 1'b0, cyc);
        check("R8 stray start run length", cyc, RUNC);
        read_all();
        check("R9 result with stray start", model_mismatch(), 0);
        repeat (5) @(negedge clk);
        check("R8 done held while idle", int'(done), 1);
        wr_en = 1'b1; wr_idx = IW'(0); wr_data = 8'd4;
        @(negedge clk); wr_en = 1'b0;
        check("R8 done cleared by write", int'(done), 0);

        // directed orderings
        for (int i = 0; i < NN; i++) loaded[i] = 8'(i + 1);
        full_trial("ascending");
        for (int i = 0; i < NN; i++) loaded[i] = 8'(200 - i);
        full_trial("descending");

        // random trials, wide and narrow value ranges
        for (int t = 0; t < 24; t++) begin
            for (int i = 0; i < NN; i++)
                loaded[i] = (t % 2 == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 3));
            full_trial($sformatf("random %0d", t));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule